// File: doc/BRIEF.md
# Paged audio controller register file

This block is the software-visible register file of a three-channel audio controller with two playback channels (0 and 1) and one capture channel (2). It answers 32-bit word accesses on a 256-byte I/O window through a simple valid/write/address port. It holds the global control word, the serial/format control word, a 4-bit page selector and a sample-count register per channel. Offsets in the upper window slice reach the per-channel frame address and frame count registers through the page selector.

The channel engines sit beside it. They read every register value through dedicated outputs. They raise a channel's pending flag with a one-cycle event pulse, and they are told to zero their leftover byte counter whenever software rewrites that channel's frame count. The three pending flags form a status word and a single interrupt line.

Top module: `pcm_csr_block`

## Requirements
- R1: After reset, a read returns control = 0x00000001, status = 0x00000060, and zero for the page selector (0x0C), the codec word (0x10), serial control (0x20) and the three sample counts (0x24, 0x28, 0x2C for channels 0, 1, 2); irq_o is low.
- R2: Control (0x00) and serial control (0x20) store all 32 written bits and read them back unchanged.
- R3: A write to the page selector (0x0C) keeps only data bits 3:0, and a read returns them with bits 31:4 zero.
- R4: A write to a sample-count register stores data bits 15:0 in both bits 31:16 (current) and bits 15:0 (reload) of that register.
- R5: A word access to an offset from 0x30 to 0x3F uses the page selector as address bits 11:8. Effective address 0xC30/0xC34 is channel 0 frame address/count, 0xC38/0xC3C is channel 1, and 0xD30/0xD34 is channel 2. These registers store all 32 bits. Any other page or offset in that slice reads 0xFFFFFFFF.
- R6: Effective addresses 0xD38 and 0xD3C ignore writes and read 0xFFFFFFFF.
- R7: A read of any offset not listed in R1 to R6, including unaligned offsets, returns 0xFFFFFFFF. A write to such an offset, or to the status or codec word, changes no readable register.
- R8: A write to a frame-count register raises lo_clr_o for that channel alone (bit index = channel) for exactly the cycle after the write. Every other write leaves lo_clr_o at zero.
- R9: An evt_set_i pulse on channel c sets that channel's pending flag only while serial-control enable bit 8+c is 1. Channel 0 appears as status bit 2, channel 1 as bit 1 and channel 2 as bit 0.
- R10: Status bit 31 and irq_o both equal the OR of the three pending flags.
- R11: A serial-control write that changes enable bit 8+c from 1 to 0 clears pending flag c. A write that leaves the bit at 1 keeps the flag.
- R12: Read data appears on rdata_o in the cycle after the read is accepted. It holds its value until the next accepted read, and writes do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 8 | Byte offset in the window |
| acc_wdata | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| evt_set_i | input | 3 | Per-channel pending-set pulse |
| irq_o | output | 1 | Interrupt line |
| ctrl_o | output | 32 | Control register value |
| sctl_o | output | 32 | Serial control register value |
| scnt_o | output | 96 | Sample counts, channel c at bits 32c+31:32c |
| faddr_o | output | 96 | Frame addresses, same packing |
| fcnt_o | output | 96 | Frame counts, same packing |
| lo_clr_o | output | 3 | Leftover-clear pulse per channel |

## Verification
A wrong page or channel decode sends data into a neighbour's frame register. The next read of either register shows it, in the cycle after that read is accepted, so the bench fills every paged slot with a distinct value before it reads them back. A pending flag stuck high, or one set while its enable is 0, shows on irq_o in the cycle after the event pulse. An enable drop that fails to clear its flag leaves irq_o high in the cycle after the serial-control write. A sweep over every enable mask and event mask exposes a wrong bit mapping in the status word on the next status read.

// File: rtl/pcm_csr_pkg.sv
`timescale 1ns/1ps
package pcm_csr_pkg;
  localparam int NCH      = 3;
  localparam int DW       = 32;
  localparam int PAGE_W   = 4;
  localparam int CH_W     = 2;

  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_STAT  = 8'h04;
  localparam logic [7:0] OFS_PAGE  = 8'h0C;
  localparam logic [7:0] OFS_CODEC = 8'h10;
  localparam logic [7:0] OFS_SCTL  = 8'h20;
  localparam logic [7:0] OFS_SCNT0 = 8'h24;
  localparam logic [7:0] WIN_LO    = 8'h30;
  localparam logic [7:0] WIN_HI    = 8'h3F;

  // pages that carry frame registers
  localparam logic [3:0] FRM_PAGE_A = 4'hC;  // channels 0 and 1
  localparam logic [3:0] FRM_PAGE_B = 4'hD;  // channel 2, upper half phantom

  localparam logic [31:0] CTRL_RST   = 32'h0000_0001;
  localparam logic [31:0] STAT_FIXED = 32'h0000_0060;
  localparam int          SUM_BIT    = 31;
  localparam int          EN_BASE    = 8;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CTRL, SEL_STAT, SEL_PAGE, SEL_CODEC,
    SEL_SCTL, SEL_SCNT, SEL_FADDR, SEL_FCNT
  } sel_e;

  typedef struct packed {
    sel_e            sel;
    logic [CH_W-1:0] ch;
  } dec_t;
endpackage

// File: rtl/pcm_csr_decode.sv
`timescale 1ns/1ps
module pcm_csr_decode
  import pcm_csr_pkg::*;
#(
  parameter int PW = PAGE_W
) (
  input  logic [7:0]    addr,
  input  logic [PW-1:0] page,
  output dec_t          dec
);
  logic in_win;

  always_comb begin
    in_win = (addr >= WIN_LO) && (addr <= WIN_HI);
    dec    = '{sel: SEL_NONE, ch: '0};
    if (in_win) begin
      if (addr[1:0] == 2'b00) begin
        if (page == PW'(FRM_PAGE_A)) begin
          dec.ch  = {1'b0, addr[3]};
          dec.sel = addr[2] ? SEL_FCNT : SEL_FADDR;
        end else if (page == PW'(FRM_PAGE_B) && !addr[3]) begin
          dec.ch  = CH_W'(2);
          dec.sel = addr[2] ? SEL_FCNT : SEL_FADDR;
        end
      end
    end else begin
      case (addr)
        OFS_CTRL:  dec.sel = SEL_CTRL;
        OFS_STAT:  dec.sel = SEL_STAT;
        OFS_PAGE:  dec.sel = SEL_PAGE;
        OFS_CODEC: dec.sel = SEL_CODEC;
        OFS_SCTL:  dec.sel = SEL_SCTL;
        OFS_SCNT0: begin dec.sel = SEL_SCNT; dec.ch = CH_W'(0); end
        OFS_SCNT0 + 8'h04: begin dec.sel = SEL_SCNT; dec.ch = CH_W'(1); end
        OFS_SCNT0 + 8'h08: begin dec.sel = SEL_SCNT; dec.ch = CH_W'(2); end
        default:   dec.sel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/pcm_chan_regs.sv
`timescale 1ns/1ps
module pcm_chan_regs #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_scnt,
  input  logic         wr_faddr,
  input  logic         wr_fcnt,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] scnt_o,
  output logic [W-1:0] faddr_o,
  output logic [W-1:0] fcnt_o,
  output logic         lo_clr_o
);
  localparam int HW = W / 2;

  logic [W-1:0] scnt_q, scnt_d, faddr_q, faddr_d, fcnt_q, fcnt_d;
  logic         lo_clr_q, lo_clr_d;

  always_comb begin
    scnt_d   = wr_scnt  ? {wdata[HW-1:0], wdata[HW-1:0]} : scnt_q;
    faddr_d  = wr_faddr ? wdata : faddr_q;
    fcnt_d   = wr_fcnt  ? wdata : fcnt_q;
    lo_clr_d = wr_fcnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scnt_q   <= '0;
      faddr_q  <= '0;
      fcnt_q   <= '0;
      lo_clr_q <= 1'b0;
    end else begin
      scnt_q   <= scnt_d;
      faddr_q  <= faddr_d;
      fcnt_q   <= fcnt_d;
      lo_clr_q <= lo_clr_d;
    end
  end

  assign scnt_o   = scnt_q;
  assign faddr_o  = faddr_q;
  assign fcnt_o   = fcnt_q;
  assign lo_clr_o = lo_clr_q;
endmodule

// File: rtl/pcm_irq_agg.sv
`timescale 1ns/1ps
module pcm_irq_agg #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] en_q,
  input  logic         en_wr,
  input  logic [N-1:0] en_new,
  input  logic [N-1:0] set_i,
  output logic [N-1:0] pend_o,
  output logic         irq_o
);
  logic [N-1:0] pend_q, pend_d, drop;

  always_comb begin
    drop   = en_wr ? (en_q & ~en_new) : '0;
    pend_d = (pend_q | (set_i & en_q)) & ~drop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;
  assign irq_o  = |pend_q;
endmodule

// File: rtl/pcm_csr_block.sv
`timescale 1ns/1ps
module pcm_csr_block
  import pcm_csr_pkg::*;
#(
  parameter int N  = NCH,
  parameter int W  = DW,
  parameter int PW = PAGE_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           acc_valid,
  input  logic           acc_write,
  input  logic [7:0]     acc_addr,
  input  logic [W-1:0]   acc_wdata,
  output logic [W-1:0]   rdata_o,
  input  logic [N-1:0]   evt_set_i,
  output logic           irq_o,
  output logic [W-1:0]   ctrl_o,
  output logic [W-1:0]   sctl_o,
  output logic [N*W-1:0] scnt_o,
  output logic [N*W-1:0] faddr_o,
  output logic [N*W-1:0] fcnt_o,
  output logic [N-1:0]   lo_clr_o
);
  logic [W-1:0]  ctrl_q, ctrl_d, sctl_q, sctl_d, rdata_q, rdata_d, rd_mux, stat_w;
  logic [PW-1:0] page_q, page_d;
  logic          wr_en, rd_en, ctrl_we, sctl_we, page_we;
  logic [N-1:0]  scnt_we, faddr_we, fcnt_we, en_q, en_new, pend;
  logic [W-1:0]  scnt_a [N];
  logic [W-1:0]  faddr_a[N];
  logic [W-1:0]  fcnt_a [N];
  dec_t          dec;

  pcm_csr_decode #(.PW(PW)) u_dec (.addr(acc_addr), .page(page_q), .dec(dec));

  assign wr_en   = acc_valid &  acc_write;
  assign rd_en   = acc_valid & ~acc_write;
  assign ctrl_we = wr_en && dec.sel == SEL_CTRL;
  assign sctl_we = wr_en && dec.sel == SEL_SCTL;
  assign page_we = wr_en && dec.sel == SEL_PAGE;

  for (genvar c = 0; c < N; c++) begin : g_ch
    assign scnt_we[c]  = wr_en && dec.sel == SEL_SCNT  && dec.ch == CH_W'(c);
    assign faddr_we[c] = wr_en && dec.sel == SEL_FADDR && dec.ch == CH_W'(c);
    assign fcnt_we[c]  = wr_en && dec.sel == SEL_FCNT  && dec.ch == CH_W'(c);
    assign en_q[c]     = sctl_q[EN_BASE+c];
    assign en_new[c]   = acc_wdata[EN_BASE+c];

    pcm_chan_regs #(.W(W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_scnt(scnt_we[c]), .wr_faddr(faddr_we[c]), .wr_fcnt(fcnt_we[c]),
      .wdata(acc_wdata),
      .scnt_o(scnt_a[c]), .faddr_o(faddr_a[c]), .fcnt_o(fcnt_a[c]),
      .lo_clr_o(lo_clr_o[c])
    );
    assign scnt_o [c*W +: W] = scnt_a[c];
    assign faddr_o[c*W +: W] = faddr_a[c];
    assign fcnt_o [c*W +: W] = fcnt_a[c];
  end

  pcm_irq_agg #(.N(N)) u_irq (
    .clk(clk), .rst_n(rst_n), .en_q(en_q), .en_wr(sctl_we), .en_new(en_new),
    .set_i(evt_set_i), .pend_o(pend), .irq_o(irq_o)
  );

  // status word: channel c pending sits at bit N-1-c, summary at the top
  always_comb begin
    stat_w = W'(STAT_FIXED);
    for (int c = 0; c < N; c++) stat_w[N-1-c] = pend[c];
    stat_w[SUM_BIT] = |pend;
  end

  always_comb begin
    rd_mux = '1;
    case (dec.sel)
      SEL_CTRL:  rd_mux = ctrl_q;
      SEL_STAT:  rd_mux = stat_w;
      SEL_PAGE:  rd_mux = W'(page_q);
      SEL_CODEC: rd_mux = '0;
      SEL_SCTL:  rd_mux = sctl_q;
      SEL_SCNT:  for (int c = 0; c < N; c++) if (dec.ch == CH_W'(c)) rd_mux = scnt_a[c];
      SEL_FADDR: for (int c = 0; c < N; c++) if (dec.ch == CH_W'(c)) rd_mux = faddr_a[c];
      SEL_FCNT:  for (int c = 0; c < N; c++) if (dec.ch == CH_W'(c)) rd_mux = fcnt_a[c];
      default:   rd_mux = '1;
    endcase
  end

  always_comb begin
    ctrl_d  = ctrl_we ? acc_wdata : ctrl_q;
    sctl_d  = sctl_we ? acc_wdata : sctl_q;
    page_d  = page_we ? acc_wdata[PW-1:0] : page_q;
    rdata_d = rd_en ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= W'(CTRL_RST);
      sctl_q  <= '0;
      page_q  <= '0;
      rdata_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      sctl_q  <= sctl_d;
      page_q  <= page_d;
      rdata_q <= rdata_d;
    end
  end

  assign rdata_o = rdata_q;
  assign ctrl_o  = ctrl_q;
  assign sctl_o  = sctl_q;
endmodule

// File: rtl/pcm_csr_chk.sv
`timescale 1ns/1ps
module pcm_csr_chk
  import pcm_csr_pkg::*;
#(
  parameter int N = NCH,
  parameter int W = DW
) (
  input logic           clk,
  input logic           rst_n,
  input logic           acc_valid,
  input logic           acc_write,
  input logic [W-1:0]   acc_wdata,
  input logic [W-1:0]   rdata_o,
  input logic           irq_o,
  input logic [N-1:0]   evt_set_i,
  input logic [N-1:0]   en_q,
  input logic [N-1:0]   pend,
  input logic           sctl_we,
  input logic [N-1:0]   scnt_we,
  input logic [N*W-1:0] scnt_o,
  input logic [N-1:0]   lo_clr_o
);
  localparam int HW = W / 2;

  for (genvar c = 0; c < N; c++) begin : g_chk
    // R9: a pending flag only rises after an enabled event
    a_r9_set_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend[c]) |-> $past(evt_set_i[c] && en_q[c]));
    // R11: dropping an enable clears the flag
    a_r11_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (sctl_we && en_q[c] && !acc_wdata[EN_BASE+c]) |=> !pend[c]);
    // R4: both halves equal after a sample-count write
    a_r4_halves_equal: assert property (@(posedge clk) disable iff (!rst_n)
      scnt_we[c] |=> (scnt_o[c*W+HW +: HW] == scnt_o[c*W +: HW]));
  end

  a_r8_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lo_clr_o));
  a_r12_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && !acc_write) |=> $stable(rdata_o));
  a_r10_irq_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(|evt_set_i));
endmodule

bind pcm_csr_block pcm_csr_chk #(.N(N), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_wdata(acc_wdata), .rdata_o(rdata_o), .irq_o(irq_o), .evt_set_i(evt_set_i),
  .en_q(en_q), .pend(pend), .sctl_we(sctl_we), .scnt_we(scnt_we),
  .scnt_o(scnt_o), .lo_clr_o(lo_clr_o)
);

// File: tb/pcm_csr_block_tb.sv
`timescale 1ns/1ps
module pcm_csr_block_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid, acc_write;
  logic [7:0]  acc_addr;
  logic [31:0] acc_wdata, rdata_o, ctrl_o, sctl_o;
  logic [2:0]  evt_set_i, lo_clr_o;
  logic        irq_o;
  logic [95:0] scnt_o, faddr_o, fcnt_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] m_ctrl, m_sctl, m_scnt[3], m_faddr[3], m_fcnt[3];
  logic [3:0]  m_page;
  logic [2:0]  m_pend;

  always #2.5 clk = ~clk;

  pcm_csr_block u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rdata_o(rdata_o),
    .evt_set_i(evt_set_i), .irq_o(irq_o), .ctrl_o(ctrl_o), .sctl_o(sctl_o),
    .scnt_o(scnt_o), .faddr_o(faddr_o), .fcnt_o(fcnt_o), .lo_clr_o(lo_clr_o)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%08h exp=%08h", req, got, exp);
    end
  endtask

  // kind: 0 none,1 ctrl,2 stat,3 page,4 codec,5 sctl,6 scnt,7 faddr,8 fcnt
  function automatic void bdec(input logic [7:0] a, output int kind, output int ch);
    int e;
    kind = 0; ch = 0;
    if (a >= 8'h30 && a <= 8'h3F) begin
      e = int'(m_page) * 256 + int'(a);
      if (e % 4 == 0) begin
        if (e >= 'hC30 && e <= 'hC3F) begin ch = (e - 'hC30) / 8; kind = ((e / 4) % 2) ? 8 : 7; end
        else if (e >= 'hD30 && e <= 'hD37) begin ch = 2; kind = ((e / 4) % 2) ? 8 : 7; end
      end
    end else begin
      case (a)
        8'h00: kind = 1;
        8'h04: kind = 2;
        8'h0C: kind = 3;
        8'h10: kind = 4;
        8'h20: kind = 5;
        8'h24, 8'h28, 8'h2C: begin kind = 6; ch = (int'(a) - 'h24) / 4; end
        default: kind = 0;
      endcase
    end
  endfunction

  function automatic logic [31:0] exp_stat();
    logic [31:0] s = 32'h60;
    for (int c = 0; c < 3; c++) if (m_pend[c]) s[2-c] = 1'b1;
    if (m_pend != 0) s[31] = 1'b1;
    return s;
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    int k, c;
    bdec(a, k, c);
    case (k)
      1: return m_ctrl;
      2: return exp_stat();
      3: return {28'h0, m_page};
      4: return 32'h0;
      5: return m_sctl;
      6: return m_scnt[c];
      7: return m_faddr[c];
      8: return m_fcnt[c];
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    int k, c;
    logic [2:0] exp_clr = 3'b000;
    bdec(a, k, c);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
    case (k)
      1: m_ctrl = d;
      3: m_page = d[3:0];
      5: begin
           for (int i = 0; i < 3; i++) if (m_sctl[8+i] && !d[8+i]) m_pend[i] = 1'b0;
           m_sctl = d;
         end
      6: m_scnt[c] = {d[15:0], d[15:0]};
      7: m_faddr[c] = d;
      8: begin m_fcnt[c] = d; exp_clr[c] = 1'b1; end
      default: ;
    endcase
    check("R8 leftover clear pulse", {29'h0, lo_clr_o}, {29'h0, exp_clr});
  endtask

  task automatic rd(input string req, input logic [7:0] a);
    logic [31:0] e;
    e = exp_read(a);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a;
    @(negedge clk);
    acc_valid = 1'b0;
    check(req, rdata_o, e);
  endtask

  task automatic pulse(input logic [2:0] s);
    @(negedge clk);
    evt_set_i = s;
    @(negedge clk);
    evt_set_i = 3'b000;
    m_pend = m_pend | (s & {m_sctl[10], m_sctl[9], m_sctl[8]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    rst_n = 1'b0; acc_valid = 1'b0; acc_write = 1'b0; acc_addr = '0;
    acc_wdata = '0; evt_set_i = '0;
    m_ctrl = 32'h1; m_sctl = 0; m_page = 0; m_pend = 0;
    for (int c = 0; c < 3; c++) begin m_scnt[c] = 0; m_faddr[c] = 0; m_fcnt[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    check("R1 irq after reset", {31'h0, irq_o}, 32'h0);
    rd("R1 ctrl reset", 8'h00);
    rd("R1 status reset", 8'h04);
    rd("R1 page reset", 8'h0C);
    rd("R1 codec reset", 8'h10);
    rd("R1 sctl reset", 8'h20);
    for (int c = 0; c < 3; c++) rd("R1 scnt reset", 8'h24 + 8'(4*c));

    // R2 walking bits through control and serial control
    for (int k = 0; k < 32; k++) begin
      wr(8'h00, 32'h1 << k);     rd("R2 ctrl walk1", 8'h00);
      wr(8'h00, ~(32'h1 << k));  rd("R2 ctrl walk0", 8'h00);
      wr(8'h20, 32'h1 << k);     rd("R2 sctl walk1", 8'h20);
      wr(8'h20, ~(32'h1 << k));  rd("R2 sctl walk0", 8'h20);
    end
    wr(8'h20, 32'h0);

    // R3 page width
    for (int v = 0; v < 32; v++) begin
      wr(8'h0C, 32'(v) * 32'h1111_1111 + 32'hF0);
      rd("R3 page masked", 8'h0C);
    end

    // R4 sample counts
    for (int c = 0; c < 3; c++)
      for (int v = 0; v < 4; v++) begin
        wr(8'h24 + 8'(4*c), {16'hDEAD + 16'(v), 16'(c * 4096 + v * 257 + 1)});
        rd("R4 scnt halves", 8'h24 + 8'(4*c));
      end

    // R5 R6 write every page x every aligned window slot, then read all slots
    for (int p = 0; p < 16; p++) begin
      wr(8'h0C, 32'(p));
      for (int o = 0; o < 4; o++)
        wr(8'h30 + 8'(4*o), 32'h1000_0000 * 32'(o + 1) + 32'(p * 16 + o));
    end
    for (int p = 0; p < 16; p++) begin
      wr(8'h0C, 32'(p));
      for (int o = 0; o < 16; o++) rd("R5 R6 paged window", 8'h30 + 8'(o));
    end
    for (int c = 0; c < 3; c++) begin
      check("R5 frame addr port", faddr_o[32*c +: 32], m_faddr[c]);
      check("R5 frame count port", fcnt_o[32*c +: 32], m_fcnt[c]);
    end

    // R7 full sweep of page 0, junk writes, sweep again
    wr(8'h0C, 32'h0);
    for (int a = 0; a < 256; a++) rd("R7 sweep", 8'(a));
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h10, 32'h1234_5678);
    wr(8'h08, 32'h5A5A_5A5A);
    wr(8'h25, 32'h5A5A_5A5A);
    wr(8'hFC, 32'h5A5A_5A5A);
    wr(8'h0D, 32'h5A5A_5A5A);
    wr(8'h0C, 32'hD); wr(8'h38, 32'h5A5A_5A5A); wr(8'h3C, 32'h5A5A_5A5A); // R6 phantom writes
    wr(8'h0C, 32'h0);
    for (int a = 0; a < 64; a++) rd("R7 after junk writes", 8'(a));
    wr(8'h0C, 32'hD);
    for (int o = 0; o < 16; o++) rd("R6 phantom after write", 8'h30 + 8'(o));
    wr(8'h0C, 32'hC);
    for (int o = 0; o < 16; o++) rd("R6 page C untouched", 8'h30 + 8'(o));

    // R9 R10 all enable masks x all event masks
    for (int e = 0; e < 8; e++)
      for (int s = 0; s < 8; s++) begin
        wr(8'h20, 32'h0);
        wr(8'h20, 32'(e) << 8);
        pulse(3'(s));
        check("R10 irq level", {31'h0, irq_o}, {31'h0, |(3'(e) & 3'(s))});
        rd("R9 R10 status pending", 8'h04);
      end

    // R11 dropping one enable at a time
    for (int c = 0; c < 3; c++) begin
      wr(8'h20, 32'h700);
      pulse(3'b111);
      wr(8'h20, 32'h700 | 32'hFF);          // enables kept
      rd("R11 keep flags", 8'h04);
      wr(8'h20, 32'h700 & ~(32'h100 << c)); // drop channel c
      rd("R11 drop clears one", 8'h04);
      check("R11 irq still set", {31'h0, irq_o}, 32'h1);
    end
    wr(8'h20, 32'h0);
    check("R11 irq cleared", {31'h0, irq_o}, 32'h0);

    // R12 read latency and hold
    wr(8'h00, 32'hCAFE_F00D);
    rd("R12 read data", 8'h00);
    held = rdata_o;
    wr(8'h00, 32'h0BAD_BEEF);
    check("R12 hold over write", rdata_o, held);
    repeat (5) @(negedge clk);
    check("R12 hold when idle", rdata_o, held);
    check("R2 ctrl port", ctrl_o, m_ctrl);
    check("R2 sctl port", sctl_o, m_sctl);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule